// File: doc/BRIEF.md
# Stereo SSD Disparity Pipeline

This block turns two synchronised 8-bit grayscale pixel streams, one from a left camera and one from a right camera, into a dense stream of disparity codes. Each frame is treated as one long vector in raster order, from top-left to bottom-right. For every pixel the block takes a window of left pixels centred on a point that lags the newest sample. It compares that window with a set of shifted windows of right pixels, using the sum of squared differences as the cost. It then reports the index of the shift with the lowest cost.

A pixel pair is offered by pulsing `pix_vld` for one cycle. The block runs on a clock much faster than the pixel rate, so each pixel period holds many internal cycles. A controller walks the work for one pixel through five steps:
- shift the new pair into the history;
- form all differences;
- square them on a few reused multiplier lanes;
- add the squares into one cost per candidate;
- pick the minimum with a comparator tree.

The controller has four states, and the last step ends in a one-cycle result strobe:
- `S_IDLE` waits for a pixel. `pix_vld` moves it to `S_DIFF` and shifts the history on the same edge.
- `S_DIFF` registers every difference and clears the cost accumulators. It always moves to `S_SQR`.
- `S_SQR` squares and accumulates one window tap for a group of candidates each cycle. On the final tap of the final group it moves to `S_MIN`.
- `S_MIN` registers the winning index and moves back to `S_IDLE`.

Top module: `stereo_disparity`

## Requirements
- R1: After reset `disp_vld` is 0 and `disp` is 0.
- R2: Each accepted pair is appended at the newest end of its history and the oldest sample is dropped, so order is kept. A right stream that equals the left one shifted by s pixels (right[x] = left[x−s], with s from −3 to +4) gives index s+3 once the window lies wholly inside that pattern.
- R3: `disp_vld` is a single-cycle pulse. It is high in the cycle after the 46th rising edge that follows the edge on which the pixel was accepted (46 = 11 taps × 4 candidate groups + 2).
- R4: The first 17 accepted pixels after reset give no pulse, and `disp` stays 0 during that time. From the 18th accepted pixel on, every accepted pixel gives exactly one pulse. Pixels near row edges get no special handling.
- R5: Let n be the index of the newest accepted pixel. The centre is k = n−9. Candidate c (0..7) stands for shift j = c−3, and its cost is the sum over t = −5..+5 of (left[k+t] − right[k+t+j])². `disp` is the unsigned index c of the lowest cost.
- R6: When two or more candidates share the lowest cost, the lowest index among them is reported.
- R7: A `pix_vld` pulse that arrives while the controller is not in `S_IDLE` is ignored. The history and all later results are the same as if the pulse had not arrived. Accepted pixels must therefore be at least 47 cycles apart.
- R8: Costs are exact up to the full-scale value 11 × 255² = 715275. This holds for windows of 0 against 255, and none of them wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | One-cycle strobe offering a new pixel pair |
| left_px | input | 8 | Left camera pixel, unsigned grayscale |
| right_px | input | 8 | Right camera pixel, unsigned grayscale |
| disp_vld | output | 1 | One-cycle strobe marking a new disparity code |
| disp | output | 3 | Winning candidate index, 0..7 (shift = index − 3) |

## Verification
A result is due exactly 47 sampling points after the accepting edge: the edge itself, one difference edge, 44 accumulation edges and the selection edge. The bench counts falling edges from the accept. It expects `disp_vld` low at the 46th point, high with the computed code at the 47th, and low again at the 48th. Stray `pix_vld` pulses are injected in the middle of that window, and the result of the following pixel is then compared against a model that never saw them.

// File: rtl/stereo_pkg.sv
package stereo_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIFF,
        S_SQR,
        S_MIN
    } stage_e;

    // Bits needed to hold win full-scale squares without wrapping.
    function automatic int cost_width(input int pix_w, input int win);
        longint full;
        full = longint'(win) * ((longint'(1) << pix_w) - 1) * ((longint'(1) << pix_w) - 1);
        return $clog2(full + 1);
    endfunction

endpackage

// File: rtl/stereo_hist.sv
module stereo_hist #(
    parameter int PIX_W = 8,
    parameter int WIN   = 11,
    parameter int SRCH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic diff_en,
    input  logic [PIX_W-1:0] left_px,
    input  logic [PIX_W-1:0] right_px,
    output logic [2*SRCH*WIN-1:0][PIX_W:0] diffs,
    output logic hist_full
);
    localparam int HALF   = (WIN - 1) / 2;
    localparam int CAND   = 2 * SRCH;
    localparam int LDEP   = 2 * HALF + SRCH + 1;
    localparam int RDEP   = 2 * HALF + 2 * SRCH;
    localparam int DIFF_W = PIX_W + 1;
    localparam int FILL_W = $clog2(RDEP + 1);

    // Element 0 holds the newest sample; higher elements are older.
    logic [LDEP-1:0][PIX_W-1:0] lh;
    logic [RDEP-1:0][PIX_W-1:0] rh;
    logic [FILL_W-1:0] fill;
    logic [CAND*WIN-1:0][DIFF_W-1:0] diff_nx;

    // Stage 1: shift the history, then place the new pair at the newest end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lh   <= '0;
            rh   <= '0;
            fill <= '0;
        end else if (shift_en) begin
            lh <= {lh[LDEP-2:0], left_px};
            rh <= {rh[RDEP-2:0], right_px};
            if (fill != FILL_W'(RDEP)) begin
                fill <= fill + 1'b1;
            end
        end
    end

    assign hist_full = (fill == FILL_W'(RDEP));

    // Stage 2: one difference per (candidate, tap).
    // A left tap u sits 2*HALF+SRCH-u samples back; the right tap for
    // candidate c sits a further c-(SRCH-1) toward the newest end.
    always_comb begin
        for (int c = 0; c < CAND; c++) begin
            for (int u = 0; u < WIN; u++) begin
                diff_nx[c*WIN+u] = {1'b0, lh[2*HALF+SRCH-u]}
                                 - {1'b0, rh[2*HALF+2*SRCH-1-u-c]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diffs <= '0;
        end else if (diff_en) begin
            diffs <= diff_nx;
        end
    end

    AST_FILL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        fill >= $past(fill)) else $error("fill count went backwards"); // R4

endmodule

// File: rtl/stereo_sqacc.sv
module stereo_sqacc #(
    parameter int PIX_W = 8,
    parameter int WIN   = 11,
    parameter int CAND  = 8,
    parameter int LANES = 2,
    parameter int SUM_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic [CAND*WIN-1:0][PIX_W:0] diffs,
    output logic [CAND-1:0][SUM_W-1:0] costs,
    output logic last_beat
);
    localparam int DIFF_W = PIX_W + 1;
    localparam int SQ_W   = 2 * PIX_W;
    localparam int NGRP   = CAND / LANES;
    localparam int TAP_W  = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int CIDX_W = (CAND > 1) ? $clog2(CAND) : 1;
    localparam int DIDX_W = $clog2(CAND * WIN);

    logic [TAP_W-1:0] tap;
    logic [GRP_W-1:0] grp;
    logic [LANES-1:0][CIDX_W-1:0] lane_cidx;
    logic [LANES-1:0][SUM_W-1:0] lane_sum;

    assign last_beat = (tap == TAP_W'(WIN - 1)) && (grp == GRP_W'(NGRP - 1));

    // Stage 3: each lane squares one difference per cycle.
    for (genvar m = 0; m < LANES; m++) begin : g_lane
        logic [DIFF_W-1:0] d;
        logic [DIFF_W-1:0] neg;
        logic [PIX_W-1:0] mag;
        logic [SQ_W-1:0] sq;
        logic [SUM_W:0] wide;

        assign lane_cidx[m] = CIDX_W'(int'(grp) * LANES + m);
        assign d    = diffs[DIDX_W'((int'(grp) * LANES + m) * WIN + int'(tap))];
        assign neg  = -d;
        assign mag  = d[DIFF_W-1] ? neg[PIX_W-1:0] : d[PIX_W-1:0];
        assign sq   = SQ_W'(mag) * SQ_W'(mag);
        assign wide = {1'b0, costs[lane_cidx[m]]} + (SUM_W + 1)'(sq);
        assign lane_sum[m] = wide[SUM_W-1:0];

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            step |-> !wide[SUM_W]) else $error("cost accumulator wrapped"); // R8
    end

    // Stage 4: per-candidate sums; tap counter runs inside the group counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            costs <= '0;
            tap   <= '0;
            grp   <= '0;
        end else if (clr) begin
            costs <= '0;
            tap   <= '0;
            grp   <= '0;
        end else if (step) begin
            for (int m = 0; m < LANES; m++) begin
                costs[lane_cidx[m]] <= lane_sum[m];
            end
            if (tap == TAP_W'(WIN - 1)) begin
                tap <= '0;
                grp <= (grp == GRP_W'(NGRP - 1)) ? '0 : grp + 1'b1;
            end else begin
                tap <= tap + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stereo_argmin.sv
module stereo_argmin #(
    parameter int CAND  = 8,
    parameter int SUM_W = 20
) (
    input  logic [CAND-1:0][SUM_W-1:0] costs,
    output logic [$clog2(CAND)-1:0] best
);
    localparam int IDX_W = $clog2(CAND);

    // Stage 5: pairwise comparator tree, reduced in place level by level.
    // The higher-index side wins only on a strictly lower cost.
    always_comb begin
        logic [SUM_W-1:0] cv [CAND];
        logic [IDX_W-1:0] iv [CAND];
        for (int c = 0; c < CAND; c++) begin
            cv[c] = costs[c];
            iv[c] = IDX_W'(c);
        end
        for (int w = CAND / 2; w >= 1; w = w / 2) begin
            for (int n = 0; n < w; n++) begin
                if (cv[2*n+1] < cv[2*n]) begin
                    cv[n] = cv[2*n+1];
                    iv[n] = iv[2*n+1];
                end else begin
                    cv[n] = cv[2*n];
                    iv[n] = iv[2*n];
                end
            end
        end
        best = iv[0];
    end

endmodule

// File: rtl/stereo_disparity.sv
module stereo_disparity #(
    parameter int PIX_W = 8,
    parameter int WIN   = 11,
    parameter int SRCH  = 4,
    parameter int LANES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_vld,
    input  logic [PIX_W-1:0] left_px,
    input  logic [PIX_W-1:0] right_px,
    output logic disp_vld,
    output logic [$clog2(2*SRCH)-1:0] disp
);
    import stereo_pkg::*;

    localparam int CAND  = 2 * SRCH;
    localparam int IDX_W = $clog2(CAND);
    localparam int SUM_W = cost_width(PIX_W, WIN);

    stage_e st, nx;
    logic shift_en, diff_en, step, last_beat, hist_full, scan_bad;
    logic [CAND*WIN-1:0][PIX_W:0] diffs;
    logic [CAND-1:0][SUM_W-1:0] costs;
    logic [IDX_W-1:0] best;

    assign shift_en = (st == S_IDLE) && pix_vld;
    assign diff_en  = (st == S_DIFF);
    assign step     = (st == S_SQR);

    stereo_hist #(.PIX_W(PIX_W), .WIN(WIN), .SRCH(SRCH)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .diff_en(diff_en),
        .left_px(left_px), .right_px(right_px), .diffs(diffs), .hist_full(hist_full)
    );

    stereo_sqacc #(.PIX_W(PIX_W), .WIN(WIN), .CAND(CAND), .LANES(LANES), .SUM_W(SUM_W)) u_sqacc (
        .clk(clk), .rst_n(rst_n), .clr(diff_en), .step(step), .diffs(diffs),
        .costs(costs), .last_beat(last_beat)
    );

    stereo_argmin #(.CAND(CAND), .SUM_W(SUM_W)) u_argmin (
        .costs(costs), .best(best)
    );

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE: if (pix_vld)   nx = S_DIFF;
            S_DIFF:                nx = S_SQR;
            S_SQR:  if (last_beat) nx = S_MIN;
            S_MIN:                 nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_vld <= 1'b0;
            disp     <= '0;
        end else begin
            disp_vld <= (st == S_MIN) && hist_full;
            if ((st == S_MIN) && hist_full) begin
                disp <= best;
            end
        end
    end

    // Independent linear scan of the tree result.
    always_comb begin
        scan_bad = 1'b0;
        for (int c = 0; c < CAND; c++) begin
            if (costs[c] < costs[best]) scan_bad = 1'b1;
            if ((IDX_W'(c) < best) && (costs[c] == costs[best])) scan_bad = 1'b1;
        end
    end

    AST_ARGMIN_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MIN) |-> !scan_bad) else $error("tree pick is not lowest-index minimum"); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |=> !disp_vld) else $error("result strobe longer than one cycle"); // R3

    AST_IDLE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> (st == S_IDLE)) else $error("result issued while controller busy"); // R7

endmodule

// File: tb/tb_stereo_disparity.sv
`timescale 1ns/1ps
module tb_stereo_disparity;
    localparam int HALF = 5;
    localparam int WIN  = 11;
    localparam int SRCH = 4;
    localparam int CAND = 8;
    localparam int LAT  = 46;
    localparam int FILL = 18;
    localparam int NPIX = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_vld = 1'b0;
    logic [7:0] left_px = '0;
    logic [7:0] right_px = '0;
    logic disp_vld;
    logic [2:0] disp;

    int checks = 0;
    int fails = 0;
    logic [7:0] lpx [NPIX];
    logic [7:0] rpx [NPIX];

    always #2 clk = ~clk;

    stereo_disparity dut (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .left_px(left_px),
        .right_px(right_px), .disp_vld(disp_vld), .disp(disp)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int exp_idx(input int n);
        int k, best;
        longint bc, cost;
        k = n - HALF - SRCH;
        best = 0;
        bc = 0;
        for (int c = 0; c < CAND; c++) begin
            cost = 0;
            for (int u = 0; u < WIN; u++) begin
                int li, ri, d;
                li = k - HALF + u;
                ri = li + c - (SRCH - 1);
                d = int'(lpx[li]) - int'(rpx[ri]);
                cost += longint'(d * d);
            end
            if (c == 0 || cost < bc) begin
                bc = cost;
                best = c;
            end
        end
        return best;
    endfunction

    function automatic string tag_for(input int n);
        if (n < FILL) return "R4";
        if (n >= 60 && n < 150) return "R2";
        if (n >= 150 && n < 170) return "R6";
        if (n >= 170 && n < 200) return "R8";
        if (n >= 200) return "R6";
        return "R5";
    endfunction

    task automatic run_pixel(input int n, input bit stray);
        string tg;
        tg = stray ? "R7" : tag_for(n);
        @(negedge clk);
        pix_vld = 1'b1;
        left_px = lpx[n];
        right_px = rpx[n];
        @(negedge clk);
        pix_vld = 1'b0;
        left_px = 8'($urandom);
        right_px = 8'($urandom);
        for (int p = 2; p <= LAT + 2; p++) begin
            @(negedge clk);
            if (stray && p == 10) begin
                pix_vld = 1'b1;
                left_px = 8'hAA;
                right_px = 8'h55;
            end else begin
                pix_vld = 1'b0;
            end
            if (p == LAT) chk("R3", "strobe early", int'(disp_vld), 0);
            if (p == LAT + 1) begin
                chk(n < FILL - 1 ? "R4" : "R3", "strobe due", int'(disp_vld), (n >= FILL - 1) ? 1 : 0);
                if (n >= FILL - 1) chk(tg, $sformatf("disp pixel %0d", n), int'(disp), exp_idx(n));
                else chk("R4", "disp before fill", int'(disp), 0);
            end
            if (p == LAT + 2) chk("R3", "strobe width", int'(disp_vld), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int x = 0; x < NPIX; x++) begin
            lpx[x] = 8'($urandom);
            rpx[x] = 8'($urandom);
        end
        for (int x = 60; x < 110; x++) rpx[x] = lpx[x-2];      // shift +2 -> index 5
        for (int x = 110; x < 150; x++) rpx[x] = lpx[x+3];     // shift -3 -> index 0
        for (int x = 150; x < 170; x++) begin lpx[x] = 8'd77; rpx[x] = 8'd77; end
        for (int x = 170; x < 200; x++) begin lpx[x] = 8'd0; rpx[x] = 8'd255; end
        rpx[185] = 8'd0;
        for (int x = 200; x < NPIX; x++) begin
            lpx[x] = 8'($urandom % 2);
            rpx[x] = 8'($urandom % 2);
        end

        repeat (3) @(negedge clk);
        chk("R1", "strobe in reset", int'(disp_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "strobe after reset", int'(disp_vld), 0);
        chk("R1", "disp after reset", int'(disp), 0);

        for (int n = 0; n < NPIX; n++) begin
            run_pixel(n, (n == 70 || n == 180 || n == 215));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule